// File: doc/BRIEF.md
# UART Interrupt Register Set

This block keeps the interrupt bookkeeping for a serial port. Four event sources come from elsewhere in the port as single-cycle pulses: transmit watermark, receive watermark, transmit empty and receive overflow. Each pulse sets a sticky pending bit. Software reads and clears the pending bits, chooses which sources may interrupt, and can raise any source on purpose. It does all of this through a small 32-bit word-access register bus.

There are three registers. The pending register is read/write, and a write clears each bit written as one. The mask register is read/write, and a write replaces its whole value. The inject register is write-only, and a write sets each bit written as one. Each of the four interrupt lines is a registered AND of its pending bit and its mask bit. The serial datapath, the FIFOs and the baud generator stay outside this block.

Top module: `uart_irq_regs`

## Requirements
- R1: After reset the pending and mask registers read zero and all four interrupt lines are low.
- R2: Each interrupt line equals its pending bit ANDed with its mask bit, as they stood one clock earlier. An update to either register therefore reaches the line one clock after the register changes.
- R3: A write to the pending register (byte offset 0x0) clears every pending bit written as one and leaves the bits written as zero unchanged.
- R4: A write to the inject register (byte offset 0x8) ORs bits [3:0] of the written value into the pending register.
- R5: A write to the mask register (byte offset 0x4) replaces all four mask bits with bits [3:0] of the written value.
- R6: The inject register reads as zero. Bits [31:4] of every read are zero. An unmapped offset reads zero, and a write to it changes nothing.
- R7: A high pulse on an event input sets the matching pending bit, and the bit stays set after the pulse ends.
- R8: When an event pulse and a clearing write to the pending register hit the same bit in the same cycle, the bit ends up set.
- R9: The bit positions in all three registers, and the index of the event input and the interrupt output, are: bit 0 transmit watermark, bit 1 receive watermark, bit 2 transmit empty, bit 3 receive overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| evt_i | input | 4 | Event pulses, indexed as in R9 |
| irq_o | output | 4 | Level interrupt lines, indexed as in R9 |

## Verification
The gating function is swept over all 256 pairs of pending and mask patterns. Pending bits are loaded through the inject register and the mask through its own write, and each line is compared with the arithmetic AND one clock later. This separates a line that follows only one operand from one that uses the wrong bit. Every clear pattern is applied to a fully set pending register and every event pattern to a cleared one, which shows whether clears remove exactly the bits written and whether events stick. A clear of all bits in the same cycle as an event pattern shows which side wins a collision. Reads of the inject register and writes to an unmapped offset confirm that neither changes observable state.

// File: rtl/uart_irq_regs.sv
module uart_irq_regs #(
  parameter int ADDR_W = 4,
  parameter int NSRC   = 4,
  parameter logic [ADDR_W-1:0] OFS_PEND = 'h0,
  parameter logic [ADDR_W-1:0] OFS_MASK = 'h4,
  parameter logic [ADDR_W-1:0] OFS_INJ  = 'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   evt_i,
  output logic [NSRC-1:0]   irq_o
);
  localparam int PAD = 32 - NSRC;

  logic [NSRC-1:0] st_q, en_q, irq_q;
  logic [NSRC-1:0] wbits;
  logic wr_pend, wr_mask, wr_inj, rd;

  assign wbits   = bus_wdata[NSRC-1:0];
  assign wr_pend = bus_valid && bus_write && bus_addr == OFS_PEND;
  assign wr_mask = bus_valid && bus_write && bus_addr == OFS_MASK;
  assign wr_inj  = bus_valid && bus_write && bus_addr == OFS_INJ;
  assign rd      = bus_valid && !bus_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      en_q  <= '0;
      irq_q <= '0;
    end else begin
      st_q  <= (st_q & ~(wr_pend ? wbits : '0)) | evt_i | (wr_inj ? wbits : '0);
      if (wr_mask) en_q <= wbits;
      irq_q <= st_q & en_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (bus_addr == OFS_PEND)      bus_rdata = {{PAD{1'b0}}, st_q};
      else if (bus_addr == OFS_MASK) bus_rdata = {{PAD{1'b0}}, en_q};
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/uart_irq_regs_chk.sv
module uart_irq_regs_chk #(
  parameter int ADDR_W = 4,
  parameter int NSRC   = 4,
  parameter logic [ADDR_W-1:0] OFS_PEND = 'h0,
  parameter logic [ADDR_W-1:0] OFS_MASK = 'h4,
  parameter logic [ADDR_W-1:0] OFS_INJ  = 'h8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NSRC-1:0]   evt_i,
  input logic [NSRC-1:0]   irq_o,
  input logic [NSRC-1:0]   st_q,
  input logic [NSRC-1:0]   en_q
);
  logic wp, wm, wi;
  assign wp = bus_valid && bus_write && bus_addr == OFS_PEND;
  assign wm = bus_valid && bus_write && bus_addr == OFS_MASK;
  assign wi = bus_valid && bus_write && bus_addr == OFS_INJ;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == ($past(st_q) & $past(en_q))); // R2
  AST_PEND_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wp && evt_i == '0) |=> st_q == ($past(st_q) & ~$past(bus_wdata[NSRC-1:0]))); // R3
  AST_INJ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wi |=> (st_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])); // R4
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wm |=> en_q == $past(bus_wdata[NSRC-1:0])); // R5
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wm |=> $stable(en_q)); // R5
  AST_INJ_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == OFS_INJ) |-> bus_rdata == 32'd0); // R6
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:NSRC] == '0); // R6
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> (st_q & $past(evt_i)) == $past(evt_i)); // R7 R8
endmodule

bind uart_irq_regs uart_irq_regs_chk #(
  .ADDR_W(ADDR_W), .NSRC(NSRC),
  .OFS_PEND(OFS_PEND), .OFS_MASK(OFS_MASK), .OFS_INJ(OFS_INJ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .evt_i(evt_i), .irq_o(irq_o), .st_q(st_q), .en_q(en_q)
);

// File: tb/tb_uart_irq_regs.sv
`timescale 1ns/1ps
module tb_uart_irq_regs;
  localparam logic [3:0] A_PEND = 4'h0, A_MASK = 4'h4, A_INJ = 4'h8, A_BAD = 4'hC;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0] evt_i = '0, irq_o;
  int vectors = 0, miscompares = 0;

  always #4 clk = ~clk;

  uart_irq_regs dut (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .evt_i(evt_i), .irq_o(irq_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] ev = 4'h0);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; evt_i = ev;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_wdata = '0; evt_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic pulse(input logic [3:0] ev);
    @(negedge clk); evt_i = ev;
    @(negedge clk); evt_i = '0;
  endtask

  initial begin
    #200000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    check("R1 irq after reset", {28'd0, irq_o}, 32'd0);
    rst_n = 1;
    rd(A_PEND, r); check("R1 pending after reset", r, 32'd0);
    rd(A_MASK, r); check("R1 mask after reset", r, 32'd0);

    // R2 R4 R5: sweep pending x mask
    for (int s = 0; s < 16; s++) begin
      for (int e = 0; e < 16; e++) begin
        wr(A_PEND, 32'hFFFF_FFFF);
        wr(A_INJ, 32'hABCD_EF00 | s);
        wr(A_MASK, 32'h1234_5670 | e);
        @(negedge clk);
        check("R2 irq gating", {28'd0, irq_o}, s & e);
        rd(A_PEND, r); check("R4 inject readback", r, s);
        rd(A_MASK, r); check("R5 mask readback", r, e);
      end
    end

    // R3: every clear pattern on a full register
    for (int c = 0; c < 16; c++) begin
      wr(A_INJ, 32'hF);
      wr(A_PEND, c);
      rd(A_PEND, r); check("R3 write-one-clear", r, 4'hF & ~c);
    end

    // R7 R9: each event pattern is sticky
    wr(A_MASK, 32'hF);
    for (int v = 0; v < 16; v++) begin
      wr(A_PEND, 32'hF);
      pulse(v);
      repeat (2) @(negedge clk);
      rd(A_PEND, r); check("R7 event sticky", r, v);
      check("R9 irq index", {28'd0, irq_o}, v);
    end

    // R8: collision, event wins
    for (int v = 1; v < 16; v++) begin
      wr(A_INJ, 32'hF);
      wr(A_PEND, 32'hF, v);
      rd(A_PEND, r); check("R8 event beats clear", r, v);
    end

    // R6: inject reads zero, unmapped writes ignored
    wr(A_INJ, 32'h5);
    rd(A_INJ, r); check("R6 inject reads zero", r, 32'd0);
    wr(A_PEND, 32'hF);
    wr(A_MASK, 32'h3);
    wr(A_BAD, 32'hFFFF_FFFF);
    rd(A_BAD, r); check("R6 unmapped reads zero", r, 32'd0);
    rd(A_PEND, r); check("R6 unmapped write no pend", r, 32'd0);
    rd(A_MASK, r); check("R6 unmapped write no mask", r, 32'h3);

    // R1: reset mid-run
    wr(A_INJ, 32'hF); wr(A_MASK, 32'hF);
    @(negedge clk); rst_n = 0; @(negedge clk);
    check("R1 irq in reset", {28'd0, irq_o}, 32'd0);
    rst_n = 1;
    rd(A_PEND, r); check("R1 pending cleared", r, 32'd0);
    rd(A_MASK, r); check("R1 mask cleared", r, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule